// File: doc/BRIEF.md
# MSI Snooping Cache-Line Controller

This block keeps a small direct-mapped cache coherent on a shared snooping bus using a write-back, write-invalidate protocol. Each line holds a tag and one of three states: Invalid, Shared (read-only) or Modified (read/write). On its processor side the block accepts one read or write request at a time and stalls the processor until the request can finish. On its bus side it issues read-miss, write-miss and write-back transactions through a request/grant handshake, and it watches the misses that other caches put on the bus.

An address splits into a line index (its low `IDX_W` bits) and a tag (the remaining upper bits). A processor access that misses or needs ownership raises `bus_req` with a command and an address and holds them until `bus_gnt`. The granted cycle is the whole atomic transaction. A dirty victim is written back in its own granted transaction before the new miss is issued. When a snooped miss finds the block Modified, the block raises `snp_flush` in the same cycle. This strobe means that this cache supplies the dirty data and that memory must abandon its own response.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, and `bus_req`, `cpu_ready` and `snp_flush` are low. A snoop to address 0 then flushes nothing.
- R2: A processor read to a line that is Invalid or holds another clean tag issues a read miss (command 01) for the request address. `cpu_ready` rises in the granted cycle, and the line becomes Shared.
- R3: A processor write to an Invalid line, to a Shared line, or to a line holding another clean tag issues a write miss (command 10) for the request address. The line becomes Modified.
- R4: A read that hits Shared, and a read or write that hits Modified, raises `cpu_ready` in the cycle of the request. It raises no `bus_req` and leaves the state unchanged.
- R5: An access that conflicts with a Modified line first issues a write-back (command 11) carrying the victim's tag and the index. After that grant it issues the miss. A read leaves the line Shared and a write leaves it Modified.
- R6: A snooped write miss (command 10) whose tag matches a Shared line makes it Invalid without a flush.
- R7: A snooped read miss (command 01) whose tag matches a Modified line raises `snp_flush` in that cycle and leaves the line Shared.
- R8: A snooped write miss that matches a Modified line raises `snp_flush` in that cycle and leaves the line Invalid.
- R9: A snoop with a different tag, a snooped read miss to a Shared line, or a snoop to an Invalid line changes no state and raises no flush.
- R10: A snoop takes priority over the processor. `cpu_ready` is low in any cycle where `snp_valid` is high. If a snoop takes away a pending victim's Modified copy, the write-back is dropped and only the miss is issued.
- R11: Once raised without grant, `bus_req` keeps its command and address until `bus_gnt`. A granted miss completes the processor request in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Block address of the request |
| cpu_ready | output | 1 | Request completes in this cycle |
| bus_req | output | 1 | Bus transaction wanted |
| bus_gnt | input | 1 | Grant; the granted cycle carries the transaction |
| bus_cmd | output | 2 | 01 read miss, 10 write miss, 11 write-back |
| bus_addr | output | ADDR_W | Transaction address |
| snp_valid | input | 1 | Another master's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding as `bus_cmd` |
| snp_addr | input | ADDR_W | Snooped block address |
| snp_flush | output | 1 | Dirty copy supplied; memory response aborted |

## Verification
The bench targets the ordering between a victim write-back and the miss that follows it. A design that issued the miss first, or merged the two, would leave the scoreboard out of order. A snoop that arrives while a write-back waits for grant is also covered. A controller that did not look at the line again would write back data it no longer owns, and the scoreboard would see an extra write-back. Tag-mismatching snoops and read snoops to Shared lines are followed by processor hits. A design that dropped the line anyway would show a bus miss where a same-cycle hit is expected. A processor hit made in the same cycle as a snoop must stall, so a design that lets the processor win that cycle is caught.

// File: rtl/msi_pkg.sv
package msi_pkg;
   typedef enum logic [1:0] {
      LN_I = 2'd0,
      LN_S = 2'd1,
      LN_M = 2'd2
   } line_st_e;

   typedef enum logic [1:0] {
      BC_NONE   = 2'd0,
      BC_RDMISS = 2'd1,
      BC_WRMISS = 2'd2,
      BC_WB     = 2'd3
   } bus_cmd_e;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_WB   = 2'd1,
      SQ_MISS = 2'd2
   } seq_st_e;
endpackage

// File: rtl/msi_tag_store.sv
module msi_tag_store
   import msi_pkg::*;
#(
   parameter int IDX_W = 2,
   parameter int TAG_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] a_idx,
   output line_st_e         a_st,
   output logic [TAG_W-1:0] a_tag,
   input  logic [IDX_W-1:0] b_idx,
   output line_st_e         b_st,
   output logic [TAG_W-1:0] b_tag,
   input  logic             s_we,
   input  logic [IDX_W-1:0] s_idx,
   input  line_st_e         s_st,
   input  logic             c_we,
   input  logic [IDX_W-1:0] c_idx,
   input  logic [TAG_W-1:0] c_tag,
   input  line_st_e         c_st
);
   localparam int LINES = 1 << IDX_W;

   line_st_e         st_arr  [LINES];
   logic [TAG_W-1:0] tag_arr [LINES];

   for (genvar g = 0; g < LINES; g++) begin : g_line
      line_st_e         st_r;
      logic [TAG_W-1:0] tag_r;
      logic             s_sel;
      logic             c_sel;

      assign s_sel = s_we && (s_idx == IDX_W'(g));
      assign c_sel = c_we && (c_idx == IDX_W'(g));

      // snoop updates win over processor fills
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_r  <= LN_I;
            tag_r <= '0;
         end else if (s_sel) begin
            st_r  <= s_st;
         end else if (c_sel) begin
            st_r  <= c_st;
            tag_r <= c_tag;
         end
      end

      assign st_arr[g]  = st_r;
      assign tag_arr[g] = tag_r;
   end

   assign a_st  = st_arr[a_idx];
   assign a_tag = tag_arr[a_idx];
   assign b_st  = st_arr[b_idx];
   assign b_tag = tag_arr[b_idx];
endmodule

// File: rtl/msi_proto.sv
module msi_proto
   import msi_pkg::*;
#(
   parameter int TAG_W = 6
) (
   input  logic             cpu_we,
   input  logic [TAG_W-1:0] cpu_tag,
   input  line_st_e         c_st,
   input  logic [TAG_W-1:0] c_tag,
   input  logic             snp_valid,
   input  bus_cmd_e         snp_cmd,
   input  logic [TAG_W-1:0] snp_tag,
   input  line_st_e         s_st,
   input  logic [TAG_W-1:0] s_tag,
   output logic             cpu_ok,
   output logic             victim_dirty,
   output line_st_e         fill_st,
   output logic             snp_we,
   output line_st_e         snp_next,
   output logic             snp_flush
);
   logic c_match;
   logic s_match;

   always_comb begin
      c_match      = (c_tag == cpu_tag) && (c_st != LN_I);
      cpu_ok       = c_match && ((c_st == LN_M) || !cpu_we);
      victim_dirty = (c_st == LN_M) && (c_tag != cpu_tag);
      fill_st      = cpu_we ? LN_M : LN_S;
   end

   always_comb begin
      s_match   = snp_valid && (s_tag == snp_tag) && (s_st != LN_I);
      snp_we    = 1'b0;
      snp_next  = s_st;
      snp_flush = 1'b0;
      if (s_match) begin
         unique case (snp_cmd)
            BC_RDMISS: begin
               if (s_st == LN_M) begin
                  snp_we    = 1'b1;
                  snp_next  = LN_S;
                  snp_flush = 1'b1;
               end
            end
            BC_WRMISS: begin
               snp_we    = 1'b1;
               snp_next  = LN_I;
               snp_flush = (s_st == LN_M);
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/msi_seq.sv
module msi_seq
   import msi_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int IDX_W  = 2,
   localparam int TAG_W = ADDR_W - IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [TAG_W-1:0]  c_tag,
   input  logic              cpu_ok,
   input  logic              victim_dirty,
   input  line_st_e          fill_st,
   input  logic              snp_valid,
   input  logic              bus_gnt,
   output logic              cpu_ready,
   output logic              bus_req,
   output bus_cmd_e          bus_cmd,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              c_we,
   output line_st_e          c_st
);
   seq_st_e cur_q, nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur_q <= SQ_IDLE;
      else        cur_q <= nxt;
   end

   always_comb begin
      nxt       = cur_q;
      cpu_ready = 1'b0;
      bus_req   = 1'b0;
      bus_cmd   = BC_NONE;
      bus_addr  = cpu_addr;
      c_we      = 1'b0;
      c_st      = fill_st;
      unique case (cur_q)
         SQ_IDLE: begin
            if (cpu_req && !snp_valid) begin
               if (cpu_ok)            cpu_ready = 1'b1;
               else if (victim_dirty) nxt = SQ_WB;
               else                   nxt = SQ_MISS;
            end
         end
         SQ_WB: begin
            // a snoop may have taken the dirty copy away meanwhile
            if (!victim_dirty) begin
               nxt = SQ_MISS;
            end else begin
               bus_req  = 1'b1;
               bus_cmd  = BC_WB;
               bus_addr = {c_tag, cpu_addr[IDX_W-1:0]};
               if (bus_gnt) begin
                  nxt  = SQ_MISS;
                  c_we = 1'b1;
                  c_st = LN_I;
               end
            end
         end
         SQ_MISS: begin
            bus_req = 1'b1;
            bus_cmd = cpu_we ? BC_WRMISS : BC_RDMISS;
            if (bus_gnt) begin
               c_we      = 1'b1;
               cpu_ready = 1'b1;
               nxt       = SQ_IDLE;
            end
         end
         default: nxt = SQ_IDLE;
      endcase
   end
endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
   import msi_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int IDX_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   output logic              cpu_ready,
   output logic              bus_req,
   input  logic              bus_gnt,
   output logic [1:0]        bus_cmd,
   output logic [ADDR_W-1:0] bus_addr,
   input  logic              snp_valid,
   input  logic [1:0]        snp_cmd,
   input  logic [ADDR_W-1:0] snp_addr,
   output logic              snp_flush
);
   localparam int TAG_W = ADDR_W - IDX_W;

   if (IDX_W < 1) begin : g_bad_idx
      $error("msi_snoop_ctrl: IDX_W must be at least 1");
   end
   if (ADDR_W <= IDX_W) begin : g_bad_addr
      $error("msi_snoop_ctrl: ADDR_W must exceed IDX_W");
   end

   line_st_e         c_st_rd, s_st_rd, fill_st, c_st_wr, snp_next;
   logic [TAG_W-1:0] c_tag_rd, s_tag_rd;
   logic             cpu_ok, victim_dirty, snp_we, c_we;
   bus_cmd_e         seq_cmd;

   msi_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .a_idx (cpu_addr[IDX_W-1:0]),
      .a_st  (c_st_rd),
      .a_tag (c_tag_rd),
      .b_idx (snp_addr[IDX_W-1:0]),
      .b_st  (s_st_rd),
      .b_tag (s_tag_rd),
      .s_we  (snp_we),
      .s_idx (snp_addr[IDX_W-1:0]),
      .s_st  (snp_next),
      .c_we  (c_we),
      .c_idx (cpu_addr[IDX_W-1:0]),
      .c_tag (cpu_addr[ADDR_W-1:IDX_W]),
      .c_st  (c_st_wr)
   );

   msi_proto #(.TAG_W(TAG_W)) u_proto (
      .cpu_we       (cpu_we),
      .cpu_tag      (cpu_addr[ADDR_W-1:IDX_W]),
      .c_st         (c_st_rd),
      .c_tag        (c_tag_rd),
      .snp_valid    (snp_valid),
      .snp_cmd      (bus_cmd_e'(snp_cmd)),
      .snp_tag      (snp_addr[ADDR_W-1:IDX_W]),
      .s_st         (s_st_rd),
      .s_tag        (s_tag_rd),
      .cpu_ok       (cpu_ok),
      .victim_dirty (victim_dirty),
      .fill_st      (fill_st),
      .snp_we       (snp_we),
      .snp_next     (snp_next),
      .snp_flush    (snp_flush)
   );

   msi_seq #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .cpu_req      (cpu_req),
      .cpu_we       (cpu_we),
      .cpu_addr     (cpu_addr),
      .c_tag        (c_tag_rd),
      .cpu_ok       (cpu_ok),
      .victim_dirty (victim_dirty),
      .fill_st      (fill_st),
      .snp_valid    (snp_valid),
      .bus_gnt      (bus_gnt),
      .cpu_ready    (cpu_ready),
      .bus_req      (bus_req),
      .bus_cmd      (seq_cmd),
      .bus_addr     (bus_addr),
      .c_we         (c_we),
      .c_st         (c_st_wr)
   );

   assign bus_cmd = seq_cmd;
endmodule

// File: rtl/msi_snoop_chk.sv
module msi_snoop_chk #(
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_ready,
   input logic              bus_req,
   input logic              bus_gnt,
   input logic [1:0]        bus_cmd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              snp_valid,
   input logic              snp_flush
);
   a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_gnt && !snp_valid |=> bus_req && $stable(bus_cmd) && $stable(bus_addr));

   a_r11_grant_completes: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_gnt && (bus_cmd != 2'b11) |-> cpu_ready);

   a_r10_snoop_stalls_cpu: assert property (@(posedge clk) disable iff (!rst_n)
      snp_valid |-> !cpu_ready);

   a_r4_ready_no_pending_req: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |-> !bus_req || bus_gnt);

   a_r5_wb_then_miss: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_gnt && (bus_cmd == 2'b11)
      |=> bus_req && ((bus_cmd == 2'b01) || (bus_cmd == 2'b10)));

   a_r8_flush_only_on_snoop: assert property (@(posedge clk) disable iff (!rst_n)
      snp_flush |-> snp_valid);
endmodule

bind msi_snoop_ctrl msi_snoop_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_ready (cpu_ready),
   .bus_req   (bus_req),
   .bus_gnt   (bus_gnt),
   .bus_cmd   (bus_cmd),
   .bus_addr  (bus_addr),
   .snp_valid (snp_valid),
   .snp_flush (snp_flush)
);

// File: tb/sim_msi_snoop_ctrl.sv
module sim_msi_snoop_ctrl;
   localparam int CLK_P = 10;
   localparam int AW    = 8;

   localparam logic [1:0] K_FLUSH = 2'd0;
   localparam logic [1:0] K_RD    = 2'd1;
   localparam logic [1:0] K_WR    = 2'd2;
   localparam logic [1:0] K_WB    = 2'd3;

   localparam logic [AW-1:0] A_ADR = 8'h11; // index 1, tag 04
   localparam logic [AW-1:0] B_ADR = 8'h21; // index 1, tag 08
   localparam logic [AW-1:0] D_ADR = 8'h13; // index 3, tag 04

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_req = 1'b0, cpu_we = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic          cpu_ready, bus_req, snp_flush;
   logic          bus_gnt = 1'b0;
   logic [1:0]    bus_cmd;
   logic [AW-1:0] bus_addr;
   logic          snp_valid = 1'b0;
   logic [1:0]    snp_cmd = 2'd0;
   logic [AW-1:0] snp_addr = '0;

   int  checks = 0;
   int  fails  = 0;
   bit  finished = 1'b0;

   typedef struct {
      logic [1:0]    kind;
      logic [AW-1:0] addr;
      string         req;
   } exp_t;
   exp_t exp_q[$];

   always #(CLK_P/2) clk = ~clk;

   msi_snoop_ctrl #(.ADDR_W(AW), .IDX_W(2)) u0 (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_ready(cpu_ready),
      .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
      .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_flush(snp_flush)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   task automatic push(input logic [1:0] k, input logic [AW-1:0] a, input string req);
      exp_t e;
      e.kind = k; e.addr = a; e.req = req;
      exp_q.push_back(e);
   endtask

   task automatic observe(input logic [1:0] k, input logic [AW-1:0] a);
      exp_t e;
      if (exp_q.size() == 0) begin
         chk(1'b0, "R5", "unexpected bus event kind/addr", {k, a}, 0);
      end else begin
         e = exp_q.pop_front();
         chk((e.kind == k) && (e.addr == a), e.req, "bus event kind/addr",
             {k, a}, {e.kind, e.addr});
      end
   endtask

   // scoreboard monitor: samples just before each rising edge
   initial begin
      forever begin
         @(negedge clk);
         #(CLK_P/2 - 1);
         if (rst_n && bus_req && bus_gnt) observe(bus_cmd, bus_addr);
         if (rst_n && snp_flush)          observe(K_FLUSH, snp_addr);
      end
   end

   task automatic cpu_op(input bit we, input logic [AW-1:0] a, input bit exp_hit,
                         input int gnt_wait, input string req);
      bit done = 1'b0;
      bit hit_path = 1'b0;
      int waited = 0;
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; bus_gnt = 1'b0;
      #1;
      chk(cpu_ready == exp_hit, req, "ready in request cycle", cpu_ready, exp_hit);
      for (int i = 0; i < 20 && !done; i++) begin
         if (cpu_ready) begin
            done = 1'b1;
            hit_path = 1'b1;
         end else begin
            if (bus_req) begin
               if (waited >= gnt_wait) begin
                  bus_gnt = 1'b1;
                  #1;
                  if (cpu_ready) done = 1'b1;
               end else begin
                  waited++;
                  chk(!cpu_ready, req, "ready while ungranted", cpu_ready, 0);
               end
            end
            @(negedge clk);
            bus_gnt = 1'b0;
            #1;
         end
      end
      chk(done, req, "request completed", done, 1);
      if (hit_path) @(negedge clk);
      cpu_req = 1'b0;
   endtask

   task automatic snoop(input logic [1:0] c, input logic [AW-1:0] a,
                        input bit exp_flush, input string req);
      @(negedge clk);
      snp_valid = 1'b1; snp_cmd = c; snp_addr = a;
      #1;
      chk(snp_flush == exp_flush, req, "flush strobe", snp_flush, exp_flush);
      if (exp_flush) push(K_FLUSH, a, req);
      @(negedge clk);
      snp_valid = 1'b0; snp_cmd = 2'd0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      chk(!bus_req && !snp_flush && !cpu_ready, "R1", "outputs in reset",
          {bus_req, snp_flush, cpu_ready}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(!bus_req && !cpu_ready, "R1", "outputs after reset", {bus_req, cpu_ready}, 0);
      snoop(K_WR, 8'h00, 1'b0, "R1");

      push(K_RD, A_ADR, "R2");            cpu_op(1'b0, A_ADR, 1'b0, 0, "R2");
      cpu_op(1'b0, A_ADR, 1'b1, 0, "R4");
      push(K_WR, A_ADR, "R3");            cpu_op(1'b1, A_ADR, 1'b0, 0, "R3");
      cpu_op(1'b1, A_ADR, 1'b1, 0, "R4");
      cpu_op(1'b0, A_ADR, 1'b1, 0, "R4");

      push(K_WB, A_ADR, "R5"); push(K_RD, B_ADR, "R5");
      cpu_op(1'b0, B_ADR, 1'b0, 0, "R5");
      cpu_op(1'b0, B_ADR, 1'b1, 0, "R5");
      push(K_WR, A_ADR, "R3");            cpu_op(1'b1, A_ADR, 1'b0, 0, "R3");
      push(K_WB, A_ADR, "R5"); push(K_WR, B_ADR, "R5");
      cpu_op(1'b1, B_ADR, 1'b0, 1, "R5");
      cpu_op(1'b1, B_ADR, 1'b1, 0, "R5");

      snoop(K_RD, B_ADR, 1'b1, "R7");
      cpu_op(1'b0, B_ADR, 1'b1, 0, "R7");
      push(K_WR, B_ADR, "R7");            cpu_op(1'b1, B_ADR, 1'b0, 0, "R7");

      snoop(K_WR, B_ADR, 1'b1, "R8");
      push(K_RD, B_ADR, "R8");            cpu_op(1'b0, B_ADR, 1'b0, 0, "R8");

      snoop(K_WR, B_ADR, 1'b0, "R6");
      push(K_RD, B_ADR, "R6");            cpu_op(1'b0, B_ADR, 1'b0, 0, "R6");

      snoop(K_WR, A_ADR, 1'b0, "R9");
      cpu_op(1'b0, B_ADR, 1'b1, 0, "R9");
      snoop(K_RD, B_ADR, 1'b0, "R9");
      cpu_op(1'b0, B_ADR, 1'b1, 0, "R9");

      push(K_WR, D_ADR, "R11");           cpu_op(1'b1, D_ADR, 1'b0, 2, "R11");
      push(K_WR, A_ADR, "R3");            cpu_op(1'b1, A_ADR, 1'b0, 0, "R3");

      // R10: snoop takes the victim while its write-back waits for grant
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = B_ADR;
      @(negedge clk); #1;
      chk(bus_req && bus_cmd == K_WB && bus_addr == A_ADR, "R10", "pending write-back",
          {bus_req, bus_cmd, bus_addr}, {1'b1, K_WB, A_ADR});
      @(negedge clk);
      snp_valid = 1'b1; snp_cmd = K_WR; snp_addr = A_ADR;
      #1;
      chk(snp_flush, "R10", "flush of victim during stall", snp_flush, 1);
      chk(!cpu_ready, "R10", "stalled during snoop", cpu_ready, 0);
      push(K_FLUSH, A_ADR, "R10");
      @(negedge clk);
      snp_valid = 1'b0; snp_cmd = 2'd0;
      #1;
      chk(!bus_req, "R10", "write-back dropped", bus_req, 0);
      @(negedge clk); #1;
      chk(bus_req && bus_cmd == K_RD && bus_addr == B_ADR, "R10", "miss after drop",
          {bus_req, bus_cmd, bus_addr}, {1'b1, K_RD, B_ADR});
      push(K_RD, B_ADR, "R10");
      bus_gnt = 1'b1;
      #1;
      chk(cpu_ready, "R11", "ready on miss grant", cpu_ready, 1);
      @(negedge clk);
      bus_gnt = 1'b0; cpu_req = 1'b0;

      // R10: a same-cycle snoop blocks even a hit
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = B_ADR;
      snp_valid = 1'b1; snp_cmd = K_RD; snp_addr = 8'h47;
      #1;
      chk(!cpu_ready && !snp_flush, "R10", "hit held off by snoop", {cpu_ready, snp_flush}, 0);
      @(negedge clk);
      snp_valid = 1'b0; snp_cmd = 2'd0;
      #1;
      chk(cpu_ready && !bus_req, "R10", "hit after snoop", {cpu_ready, bus_req}, 2);
      @(negedge clk);
      cpu_req = 1'b0;

      repeat (2) @(negedge clk);
      chk(exp_q.size() == 0, "R5", "scoreboard drained", exp_q.size(), 0);
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(CLK_P * 20000);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog run did not complete actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule